// File: doc/BRIEF.md
# UART interrupt identification controller

This block collects the interrupt conditions of a serial port and reports them. A status field names the most urgent enabled condition, and a single interrupt line is asserted while any enabled condition is pending. The serial port's datapath signals events into the block: a line error, a receive character time-out, the transmit holding register going empty, and a change on a modem control input. The datapath also supplies the current receive FIFO fill count. The register file signals which registers are being accessed. Each condition is then cleared by its own access, or by the receive FIFO level.

The block also turns a 2-bit receive trigger code into a byte threshold. The threshold depends on the FIFO depth selected at run time. It compares the live fill count against that threshold to raise the data-available condition. Software reads the status through the 4-bit identification value. A transmit-empty condition is acknowledged by reading that value while it is the one being reported.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset, and whenever no enabled condition is pending, `iir_o` reads 4'b0001 and `irq_o` is low.
- R2: `iir_o[0]` is an active-low pending flag (0 = pending) and `irq_o` is its inverse. `iir_o[3:1]` carries the code of the most urgent enabled condition. Urgency from highest to lowest: line error 3'b011, receive data available 3'b010, receive time-out 3'b110, transmit empty 3'b001, modem change 3'b000.
- R3: A line error latches the line condition. A line status read (`lsr_rd`) clears it.
- R4: Receive data available is pending in the cycle after a cycle in which `rx_count` is at or above the trigger threshold and `rbr_rd` is low. It is therefore dropped by a receive buffer read, and also when the count falls below the threshold.
- R5: A receive time-out latches the time-out condition (code 3'b110). A receive buffer read clears it. While both are pending, data available is reported ahead of it.
- R6: A transmit-empty event latches the transmit condition. A write to the transmit data register (`thr_wr`) clears it.
- R7: An identification read (`iir_rd`) clears the transmit condition only when 3'b001 is the code being reported. That read sees the transmit code, and the clear is visible from the next cycle. A read while the condition is masked or outranked leaves it pending.
- R8: A modem change latches the modem condition. A modem status read (`msr_rd`) clears it.
- R9: Trigger thresholds for codes 0..3 depend on `depth_sel`. For 0 (16-byte FIFO) they are 1/4/8/14. For 1 (64-byte) they are 1/16/32/56. For 2 (256-byte) they are 1/32/64/128. For 3 (1024-byte) they are 1/64/128/256.
- R10: `src_en` bit 0 enables line, bit 1 enables receive data and time-out, bit 2 enables transmit empty, and bit 3 enables modem. A disabled condition stays latched but is absent from both `iir_o` and `irq_o` until it is enabled.
- R11: If a set event coincides with that condition's clearing access, the condition stays pending.
- R12: An event raised in one cycle appears in `iir_o` and `irq_o` from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_en | input | 4 | Per-source enables (line, rx, tx empty, modem) |
| depth_sel | input | 2 | FIFO depth select: 16/64/256/1024 bytes |
| trig_sel | input | 2 | Receive trigger code |
| rx_count | input | CNT_W (11) | Current receive FIFO fill count |
| line_err_evt | input | 1 | Line error event pulse |
| rx_tmo_evt | input | 1 | Receive character time-out pulse |
| tx_empty_evt | input | 1 | Transmit holding register empty pulse |
| modem_evt | input | 1 | Modem input change pulse |
| lsr_rd | input | 1 | Line status register read strobe |
| rbr_rd | input | 1 | Receive buffer read strobe |
| iir_rd | input | 1 | Identification register read strobe |
| msr_rd | input | 1 | Modem status register read strobe |
| thr_wr | input | 1 | Transmit data register write strobe |
| iir_o | output | 4 | Identification value: code in [3:1], active-low pending in [0] |
| irq_o | output | 1 | Interrupt request |

## Verification
Every event, access strobe and change of `rx_count` takes effect at the next rising edge. So `iir_o` and `irq_o` are due exactly one cycle later. Enable changes are the exception: they act combinationally within the same cycle. The bench drives on the falling edge and samples on the following falling edge, after exactly one rising edge. A behavioural model updated on the same rising edge is compared on every cycle. The identification read that acknowledges a transmit-empty condition is also sampled in its own cycle, to confirm it still returns the transmit code.

// File: rtl/uirq_pkg.sv
package uirq_pkg;

    typedef enum logic [2:0] {
        ID_MODEM  = 3'b000,
        ID_TXEMPT = 3'b001,
        ID_RXDATA = 3'b010,
        ID_LINE   = 3'b011,
        ID_RXTMO  = 3'b110
    } irq_id_e;

    // Latched event sources (index into generated flag array)
    localparam int FLG_LINE  = 0;
    localparam int FLG_TMO   = 1;
    localparam int FLG_TXE   = 2;
    localparam int FLG_MODEM = 3;
    localparam int N_FLAGS   = 4;

    // Enable bit positions
    localparam int EN_LINE  = 0;
    localparam int EN_RX    = 1;
    localparam int EN_TXE   = 2;
    localparam int EN_MODEM = 3;

    typedef struct packed {
        logic modem;
        logic txe;
        logic tmo;
        logic rxd;
        logic line;
    } src_vec_t;

    // Receive trigger threshold in bytes for a depth selection and code
    function automatic int unsigned trig_bytes(input logic [1:0] depth,
                                               input logic [1:0] code);
        int unsigned lvl;
        lvl = 1;
        case (depth)
            2'd0: case (code)
                      2'd1: lvl = 4;
                      2'd2: lvl = 8;
                      2'd3: lvl = 14;
                      default: lvl = 1;
                  endcase
            2'd1: case (code)
                      2'd1: lvl = 16;
                      2'd2: lvl = 32;
                      2'd3: lvl = 56;
                      default: lvl = 1;
                  endcase
            2'd2: case (code)
                      2'd1: lvl = 32;
                      2'd2: lvl = 64;
                      2'd3: lvl = 128;
                      default: lvl = 1;
                  endcase
            default: case (code)
                      2'd1: lvl = 64;
                      2'd2: lvl = 128;
                      2'd3: lvl = 256;
                      default: lvl = 1;
                  endcase
        endcase
        return lvl;
    endfunction

endpackage

// File: rtl/uirq_evt_flag.sv
module uirq_evt_flag (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    always_ff @(posedge clk) begin
        if (rst)
            flag_o <= 1'b0;
        else if (set_i)
            flag_o <= 1'b1;
        else if (clr_i)
            flag_o <= 1'b0;
    end
endmodule

// File: rtl/uirq_trig_decode.sv
module uirq_trig_decode #(
    parameter int CNT_W = 11
) (
    input  logic [1:0]       depth_sel,
    input  logic [1:0]       trig_sel,
    input  logic [CNT_W-1:0] rx_count,
    output logic             at_level_o
);
    import uirq_pkg::*;

    localparam int CMP_W = (CNT_W > 16) ? CNT_W : 16;

    logic [CMP_W-1:0] level;
    logic [CMP_W-1:0] count_ext;

    always_comb begin
        level      = CMP_W'(trig_bytes(depth_sel, trig_sel));
        count_ext  = CMP_W'(rx_count);
        at_level_o = (count_ext >= level);
    end
endmodule

// File: rtl/uirq_prio_enc.sv
module uirq_prio_enc (
    input  uirq_pkg::src_vec_t pend_i,
    output uirq_pkg::irq_id_e  id_o,
    output logic               any_o
);
    import uirq_pkg::*;

    always_comb begin
        any_o = |pend_i;
        if (pend_i.line)
            id_o = ID_LINE;
        else if (pend_i.rxd)
            id_o = ID_RXDATA;
        else if (pend_i.tmo)
            id_o = ID_RXTMO;
        else if (pend_i.txe)
            id_o = ID_TXEMPT;
        else
            id_o = ID_MODEM;
    end
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident #(
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [3:0]       src_en,
    input  logic [1:0]       depth_sel,
    input  logic [1:0]       trig_sel,
    input  logic [CNT_W-1:0] rx_count,
    input  logic             line_err_evt,
    input  logic             rx_tmo_evt,
    input  logic             tx_empty_evt,
    input  logic             modem_evt,
    input  logic             lsr_rd,
    input  logic             rbr_rd,
    input  logic             iir_rd,
    input  logic             msr_rd,
    input  logic             thr_wr,
    output logic [3:0]       iir_o,
    output logic             irq_o
);
    import uirq_pkg::*;

    logic [N_FLAGS-1:0] flg_set;
    logic [N_FLAGS-1:0] flg_clr;
    logic [N_FLAGS-1:0] flg_q;
    logic               rx_at_level;
    logic               rxd_q;
    src_vec_t           masked;
    irq_id_e            cur_id;
    logic               cur_any;
    logic               txe_ack;

    // Transmit-empty acknowledge: identification read while it is reported
    assign txe_ack = iir_rd && cur_any && (cur_id == ID_TXEMPT);

    always_comb begin
        flg_set            = '0;
        flg_clr            = '0;
        flg_set[FLG_LINE]  = line_err_evt;
        flg_clr[FLG_LINE]  = lsr_rd;
        flg_set[FLG_TMO]   = rx_tmo_evt;
        flg_clr[FLG_TMO]   = rbr_rd;
        flg_set[FLG_TXE]   = tx_empty_evt;
        flg_clr[FLG_TXE]   = thr_wr | txe_ack;
        flg_set[FLG_MODEM] = modem_evt;
        flg_clr[FLG_MODEM] = msr_rd;
    end

    for (genvar g = 0; g < N_FLAGS; g++) begin : g_flag
        uirq_evt_flag u_flag (
            .clk    (clk),
            .rst    (rst),
            .set_i  (flg_set[g]),
            .clr_i  (flg_clr[g]),
            .flag_o (flg_q[g])
        );
    end

    uirq_trig_decode #(.CNT_W(CNT_W)) u_trig (
        .depth_sel  (depth_sel),
        .trig_sel   (trig_sel),
        .rx_count   (rx_count),
        .at_level_o (rx_at_level)
    );

    // Data-available follows the fill level; a buffer read drops it for a cycle
    always_ff @(posedge clk) begin
        if (rst)
            rxd_q <= 1'b0;
        else
            rxd_q <= rx_at_level & ~rbr_rd;
    end

    always_comb begin
        masked.line  = flg_q[FLG_LINE]  & src_en[EN_LINE];
        masked.rxd   = rxd_q            & src_en[EN_RX];
        masked.tmo   = flg_q[FLG_TMO]   & src_en[EN_RX];
        masked.txe   = flg_q[FLG_TXE]   & src_en[EN_TXE];
        masked.modem = flg_q[FLG_MODEM] & src_en[EN_MODEM];
    end

    uirq_prio_enc u_enc (
        .pend_i (masked),
        .id_o   (cur_id),
        .any_o  (cur_any)
    );

    always_comb begin
        iir_o = cur_any ? {cur_id, 1'b0} : 4'b0001;
        irq_o = |{masked.line, masked.rxd, masked.tmo, masked.txe, masked.modem};
    end
endmodule

// File: rtl/uart_irq_ident_chk.sv
module uart_irq_ident_chk (
    input logic       clk,
    input logic       rst,
    input logic       en_line,
    input logic       line_err_evt,
    input logic       rx_tmo_evt,
    input logic       tx_empty_evt,
    input logic       modem_evt,
    input logic       lsr_rd,
    input logic       rbr_rd,
    input logic       iir_rd,
    input logic       msr_rd,
    input logic       thr_wr,
    input logic [3:0] iir_o,
    input logic       irq_o
);
    AST_IDLE_CODE: assert property (@(posedge clk) disable iff (rst)
        !irq_o |-> iir_o == 4'b0001); // R1
    AST_PEND_LOW: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> !iir_o[0]); // R2
    AST_LINE_CLEAR: assert property (@(posedge clk) disable iff (rst)
        lsr_rd && !line_err_evt |=> iir_o[3:1] != 3'b011); // R3
    AST_TMO_CLEAR: assert property (@(posedge clk) disable iff (rst)
        rbr_rd && !rx_tmo_evt |=> iir_o != 4'b1100); // R5
    AST_TXE_WR_CLEAR: assert property (@(posedge clk) disable iff (rst)
        thr_wr && !tx_empty_evt |=> iir_o[3:1] != 3'b001); // R6
    AST_TXE_READ_CLEAR: assert property (@(posedge clk) disable iff (rst)
        iir_rd && iir_o == 4'b0010 && !tx_empty_evt |=> iir_o != 4'b0010); // R7
    AST_MODEM_CLEAR: assert property (@(posedge clk) disable iff (rst)
        msr_rd && !modem_evt |=> iir_o != 4'b0000); // R8
    AST_LINE_NEXT: assert property (@(posedge clk) disable iff (rst)
        line_err_evt && en_line |=> (iir_o == 4'b0110 || !en_line)); // R12
endmodule

bind uart_irq_ident uart_irq_ident_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .en_line      (src_en[0]),
    .line_err_evt (line_err_evt),
    .rx_tmo_evt   (rx_tmo_evt),
    .tx_empty_evt (tx_empty_evt),
    .modem_evt    (modem_evt),
    .lsr_rd       (lsr_rd),
    .rbr_rd       (rbr_rd),
    .iir_rd       (iir_rd),
    .msr_rd       (msr_rd),
    .thr_wr       (thr_wr),
    .iir_o        (iir_o),
    .irq_o        (irq_o)
);

// File: tb/uart_irq_ident_test.sv
`timescale 1ns/1ps
module uart_irq_ident_test;
    localparam int CW = 11;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [3:0]    src_en = 4'hF;
    logic [1:0]    depth_sel = 2'd0;
    logic [1:0]    trig_sel = 2'd0;
    logic [CW-1:0] rx_count = '0;
    logic line_err_evt = 0, rx_tmo_evt = 0, tx_empty_evt = 0, modem_evt = 0;
    logic lsr_rd = 0, rbr_rd = 0, iir_rd = 0, msr_rd = 0, thr_wr = 0;
    logic [3:0]    iir_o;
    logic          irq_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #2 clk = ~clk; // 250 MHz

    uart_irq_ident #(.CNT_W(CW)) uut (
        .clk(clk), .rst(rst), .src_en(src_en), .depth_sel(depth_sel),
        .trig_sel(trig_sel), .rx_count(rx_count),
        .line_err_evt(line_err_evt), .rx_tmo_evt(rx_tmo_evt),
        .tx_empty_evt(tx_empty_evt), .modem_evt(modem_evt),
        .lsr_rd(lsr_rd), .rbr_rd(rbr_rd), .iir_rd(iir_rd),
        .msr_rd(msr_rd), .thr_wr(thr_wr), .iir_o(iir_o), .irq_o(irq_o)
    );

    // ---------------- behavioural reference model ----------------
    bit m_line, m_rxd, m_tmo, m_txe, m_msr;

    function automatic int bench_level(int d, int c);
        int tbl [4][4] = '{'{1, 4, 8, 14}, '{1, 16, 32, 56},
                           '{1, 32, 64, 128}, '{1, 64, 128, 256}};
        return tbl[d][c];
    endfunction

    function automatic logic [3:0] model_iir();
        if (m_line && src_en[0]) return 4'b0110;
        if (m_rxd  && src_en[1]) return 4'b0100;
        if (m_tmo  && src_en[1]) return 4'b1100;
        if (m_txe  && src_en[2]) return 4'b0010;
        if (m_msr  && src_en[3]) return 4'b0000;
        return 4'b0001;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_line <= 0; m_rxd <= 0; m_tmo <= 0; m_txe <= 0; m_msr <= 0;
        end else begin
            m_line <= line_err_evt ? 1'b1 : (lsr_rd ? 1'b0 : m_line);
            m_tmo  <= rx_tmo_evt   ? 1'b1 : (rbr_rd ? 1'b0 : m_tmo);
            m_msr  <= modem_evt    ? 1'b1 : (msr_rd ? 1'b0 : m_msr);
            m_txe  <= tx_empty_evt ? 1'b1 :
                      ((thr_wr || (iir_rd && model_iir() == 4'b0010)) ? 1'b0 : m_txe);
            m_rxd  <= (int'(rx_count) >= bench_level(int'(depth_sel), int'(trig_sel))) && !rbr_rd;
        end
    end

    task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model (R2 coding, R12 timing)
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk("R2 model iir", iir_o, model_iir());
            chk("R12 model irq", {3'b000, irq_o}, {3'b000, model_iir() != 4'b0001});
        end
    end

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        line_err_evt = 0; rx_tmo_evt = 0; tx_empty_evt = 0; modem_evt = 0;
        lsr_rd = 0; rbr_rd = 0; iir_rd = 0; msr_rd = 0; thr_wr = 0;
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        // R1 reset state
        chk("R1 reset iir", iir_o, 4'b0001);
        chk("R1 reset irq", {3'b000, irq_o}, 4'b0000);

        // R12 modem event seen next cycle
        modem_evt = 1; tick();
        chk("R12 modem next cycle", iir_o, 4'b0000);
        chk("R8 irq raised", {3'b000, irq_o}, 4'b0001);

        // R2 transmit empty outranks modem
        tx_empty_evt = 1; tick();
        chk("R2 txe over modem", iir_o, 4'b0010);

        // R7 read sees txe code, cleared next cycle
        iir_rd = 1; #1;
        chk("R7 read returns txe", iir_o, 4'b0010);
        tick();
        chk("R7 txe cleared by read", iir_o, 4'b0000);

        // R8 modem cleared by status read
        msr_rd = 1; tick();
        chk("R8 modem cleared", iir_o, 4'b0001);

        // R6 transmit write clears
        tx_empty_evt = 1; tick();
        thr_wr = 1; tick();
        chk("R6 txe cleared by write", iir_o, 4'b0001);

        // R3 / R4 line over data available
        rx_count = 1; line_err_evt = 1; tick();
        chk("R3 line reported", iir_o, 4'b0110);
        lsr_rd = 1; tick();
        chk("R3 line cleared, R4 rxd shown", iir_o, 4'b0100);
        rbr_rd = 1; tick();
        chk("R4 rxd dropped by read", iir_o, 4'b0001);
        tick();
        chk("R4 rxd back while above level", iir_o, 4'b0100);
        rx_count = 0; tick();
        chk("R4 rxd cleared below level", iir_o, 4'b0001);

        // R5 time-out: below data available, cleared by buffer read
        trig_sel = 2'd1; rx_count = 5; rx_tmo_evt = 1; tick();
        chk("R5 rxd ahead of timeout", iir_o, 4'b0100);
        rx_count = 2; tick();
        chk("R5 timeout code", iir_o, 4'b1100);
        rbr_rd = 1; tick();
        chk("R5 timeout cleared", iir_o, 4'b0001);

        // R9 trigger decode across depths and codes
        for (int d = 0; d < 4; d++) begin
            for (int c = 0; c < 4; c++) begin
                depth_sel = 2'(d); trig_sel = 2'(c);
                rx_count = CW'(bench_level(d, c) - 1); tick();
                chk($sformatf("R9 below d%0d c%0d", d, c), iir_o, 4'b0001);
                rx_count = CW'(bench_level(d, c)); tick();
                chk($sformatf("R9 at level d%0d c%0d", d, c), iir_o, 4'b0100);
            end
        end
        rx_count = 0; depth_sel = 0; trig_sel = 0; tick();

        // R10 enables mask but keep state
        src_en = 4'b1110; line_err_evt = 1; tick();
        chk("R10 masked line iir", iir_o, 4'b0001);
        chk("R10 masked line irq", {3'b000, irq_o}, 4'b0000);
        src_en = 4'hF; #1;
        chk("R10 enabled line shows", iir_o, 4'b0110);
        lsr_rd = 1; tick();
        chk("R3 line cleared again", iir_o, 4'b0001);

        // R7 read with txe masked does not clear it
        src_en = 4'b1011; tx_empty_evt = 1; modem_evt = 1; tick();
        chk("R7 modem shown while txe masked", iir_o, 4'b0000);
        iir_rd = 1; tick();
        src_en = 4'hF; #1;
        chk("R7 txe survived masked read", iir_o, 4'b0010);

        // R11 set wins against clearing write
        thr_wr = 1; tx_empty_evt = 1; tick();
        chk("R11 set wins", iir_o, 4'b0010);
        thr_wr = 1; msr_rd = 1; tick();
        chk("R11 then cleared", iir_o, 4'b0001);

        tick();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule